// File: doc/BRIEF.md
# Instruction-Driven Video DMA Sequencer

This block is a small command engine that moves captured pixel data from a data FIFO into host memory. It does not use descriptor registers. It fetches a stream of command words from host memory through a simple fetch port, decodes each command and executes it:

- Write commands issue write beats on a valid/ready bus, one FIFO DWORD per beat.
- Skip commands drain FIFO data without writing it.
- Jump commands redirect the program counter.
- Sync commands park the engine until a field of the chosen parity begins.

Two program entry points are supplied, one for odd fields and one for even fields. A field start that the engine is not waiting for re-aligns it: execution restarts at the entry point of the new field. This covers the case where the program and the pixel stream disagree on how much data a field holds. A command may request a one-cycle interrupt pulse when it completes. An unknown opcode stops the engine and raises a sticky error.

Top module: `vid_dma_seq`

## Requirements
- R1: After reset, `pc` reads 0, `err` and `irq` are low, and there are no fetch, write or FIFO-read requests. The engine stays idle, even when FIFO data is present, until the first field start.
- R2: When `fld_sof` is high in any non-halted state, the engine abandons its current work. It then fetches from `base_odd` when `fld_odd`=1 and from `base_even` when `fld_odd`=0. The one exception is the matching sync case in R8.
- R3: The command layout is opcode in bits 31:28, byte count in bits 11:0, start-of-line in bit 27, end-of-line in bit 26 and interrupt request in bit 24. Lengths in words are: 0001 write 2, 0010 skip 1, 0101 continue-write 1, 0111 jump 2, 1000 sync 2, 1001 three-plane write 5, 1010 three-plane skip 2, 1011 split write 3. Words are fetched in order, and `pc` advances by 4 per accepted word.
- R4: A write sends its byte count from the address held in word 1. Every beat pops one FIFO DWORD and carries 4 bytes, except the last, which carries the remainder (1 to 4). A beat is offered only while `fifo_avail` covers its size. A count of 0 produces no beats.
- R5: A continue-write (0101) starts at the byte address that follows the last byte of the most recent write.
- R6: A skip pops the same DWORDs a write of that count would pop, but issues no write.
- R7: A jump loads `pc` with word 1.
- R8: A sync waits for a field start whose parity matches its bit 0 (1 = odd). On a match it resumes at the following command. On a mismatch it falls under R2.
- R9: `wr_sol` is high on the first beat of a command with bit 27 set. `wr_eol` is high on the last beat of a command with bit 26 set.
- R10: A command with bit 24 set raises `irq` for exactly one cycle after it completes. A jump completes when it is decoded, and a sync completes when it is released.
- R11: Any other opcode halts the engine with `pc` just past that word, and sets `err`. The error stays set until reset, and the engine makes no further requests and ignores field starts.
- R12: The three-plane and split commands fetch all their words. They then act on the single FIFO exactly as a write (1001, 1011) or a skip (1010) would, using word 1 as the address.
- R13: A write beat that is not accepted keeps `wr_valid`, `wr_addr` and `wr_nbytes` unchanged until `wr_ready`. `fifo_rd` pulses exactly on accepted beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_odd | input | AW | Program entry point for odd fields |
| base_even | input | AW | Program entry point for even fields |
| fld_sof | input | 1 | One-cycle field start pulse |
| fld_odd | input | 1 | Parity of the field that is starting |
| if_req | output | 1 | Command word fetch request |
| if_addr | output | AW | Fetch address |
| if_data | input | 32 | Fetched command word |
| if_valid | input | 1 | Fetched word is valid this cycle |
| fifo_data | input | 32 | Head DWORD of the pixel FIFO |
| fifo_avail | input | AVW | Bytes available in the FIFO |
| fifo_rd | output | 1 | Pop one DWORD from the FIFO |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | AW | Write byte address |
| wr_data | output | 32 | Write data |
| wr_nbytes | output | 3 | Bytes in this beat, 1 to 4 |
| wr_sol | output | 1 | First beat of a line-start command |
| wr_eol | output | 1 | Last beat of a line-end command |
| pc | output | AW | Program counter readback |
| irq | output | 1 | Command completion interrupt pulse |
| err | output | 1 | Sticky unknown-opcode error |

## Verification
The hardest states to reach from the ports are a field start that lands while a write is only partly done, and a field start of the wrong parity that lands on a parked sync. The stimulus reaches both by starving the FIFO. It loads only enough DWORDs for part of a write, waits until the ports have been quiet for many cycles, and only then pulses the field start. The reference model predicts exactly where the engine must restart, so the resulting `pc` and the writes that follow can be checked.

// File: rtl/vid_dma_seq.sv
module vid_dma_seq #(
  parameter int AW  = 32,
  parameter int CW  = 12,
  parameter int AVW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  base_odd,
  input  logic [AW-1:0]  base_even,
  input  logic           fld_sof,
  input  logic           fld_odd,
  output logic           if_req,
  output logic [AW-1:0]  if_addr,
  input  logic [31:0]    if_data,
  input  logic           if_valid,
  input  logic [31:0]    fifo_data,
  input  logic [AVW-1:0] fifo_avail,
  output logic           fifo_rd,
  output logic           wr_valid,
  input  logic           wr_ready,
  output logic [AW-1:0]  wr_addr,
  output logic [31:0]    wr_data,
  output logic [2:0]     wr_nbytes,
  output logic           wr_sol,
  output logic           wr_eol,
  output logic [AW-1:0]  pc,
  output logic           irq,
  output logic           err
);
  localparam logic [3:0] OP_WR = 4'b0001, OP_SK = 4'b0010, OP_WC = 4'b0101, OP_JMP = 4'b0111,
                         OP_SYN = 4'b1000, OP_W3 = 4'b1001, OP_S3 = 4'b1010, OP_WS = 4'b1011;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_MOVE, S_WAIT, S_HALT} st_t;

  function automatic logic [2:0] op_len(input logic [3:0] op);
    case (op)
      OP_WR, OP_JMP, OP_SYN, OP_S3: op_len = 3'd2;
      OP_SK, OP_WC:                 op_len = 3'd1;
      OP_W3:                        op_len = 3'd5;
      OP_WS:                        op_len = 3'd3;
      default:                      op_len = 3'd0;
    endcase
  endfunction

  st_t           st;
  logic [2:0]    wcnt;
  logic [31:0]   ir;
  logic [AW-1:0] tgt, waddr, nxt;
  logic [CW-1:0] rem;
  logic          first, par;

  logic [31:0]   cur;
  logic [AW-1:0] dw1;
  logic [3:0]    cop, op;
  logic [2:0]    clen, beat;
  logic          is_wr, avail_ok, fire;

  assign cur      = (wcnt == 3'd0) ? if_data : ir;
  assign dw1      = (wcnt == 3'd1) ? if_data[AW-1:0] : tgt;
  assign cop      = cur[31:28];
  assign clen     = op_len(cop);
  assign op       = ir[31:28];
  assign is_wr    = (op == OP_WR) || (op == OP_WC) || (op == OP_W3) || (op == OP_WS);
  assign beat     = (rem >= CW'(4)) ? 3'd4 : rem[2:0];
  assign avail_ok = (rem != '0) && (fifo_avail >= AVW'(beat));

  assign if_req    = (st == S_FETCH);
  assign if_addr   = pc;
  assign wr_valid  = (st == S_MOVE) && is_wr && avail_ok;
  assign fire      = (st == S_MOVE) && avail_ok && (!is_wr || wr_ready);
  assign fifo_rd   = fire;
  assign wr_addr   = waddr;
  assign wr_data   = fifo_data;
  assign wr_nbytes = beat;
  assign wr_sol    = first && ir[27];
  assign wr_eol    = ir[26] && (rem <= CW'(4));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pc <= '0; wcnt <= '0; ir <= '0; tgt <= '0; waddr <= '0;
      nxt <= '0; rem <= '0; first <= 1'b0; par <= 1'b0; irq <= 1'b0; err <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (fld_sof && st != S_HALT) begin
        if (st == S_WAIT && fld_odd == par) begin
          st  <= S_FETCH;
          irq <= ir[24];
        end else begin
          pc   <= fld_odd ? base_odd : base_even;
          st   <= S_FETCH;
          wcnt <= '0;
        end
      end else begin
        case (st)
          S_FETCH: if (if_valid) begin
            pc <= pc + AW'(4);
            if (wcnt == 3'd0) ir  <= if_data;
            if (wcnt == 3'd1) tgt <= if_data[AW-1:0];
            if (clen == 3'd0) begin
              st  <= S_HALT;
              err <= 1'b1;
            end else if (wcnt == clen - 3'd1) begin
              wcnt <= '0;
              case (cop)
                OP_JMP: begin pc <= dw1; irq <= cur[24]; end
                OP_SYN: begin st <= S_WAIT; par <= cur[0]; end
                default: begin
                  st    <= S_MOVE;
                  rem   <= cur[CW-1:0];
                  first <= 1'b1;
                  waddr <= (cop == OP_WC) ? nxt : dw1;
                end
              endcase
            end else begin
              wcnt <= wcnt + 3'd1;
            end
          end
          S_MOVE: if (rem == '0) begin
            st  <= S_FETCH;
            irq <= ir[24];
            if (is_wr) nxt <= waddr;
          end else if (fire) begin
            rem   <= rem - CW'(beat);
            waddr <= waddr + AW'(beat);
            first <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // R13
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready && !fld_sof |=> wr_valid && $stable(wr_addr) && $stable(wr_nbytes));
  // R3
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_req && !if_valid && !fld_sof |=> if_req && $stable(if_addr));
  // R4
  beat_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_nbytes != 3'd0) && (wr_nbytes <= 3'd4));
  // R6
  pop_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> fifo_avail != '0);
  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R11
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !if_req && !wr_valid && !fifo_rd);
endmodule

// File: tb/vid_dma_seq_bench.sv
`timescale 1ns/1ps
module vid_dma_seq_bench;
  localparam logic [31:0] BODD = 32'h1000, BEVEN = 32'h2000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, fld_sof, fld_odd, if_req, if_valid, fifo_rd, wr_valid, wr_ready;
  logic wr_sol, wr_eol, irq, err;
  logic [31:0] if_addr, if_data, fifo_data, wr_addr, wr_data, pc;
  logic [9:0]  fifo_avail;
  logic [2:0]  wr_nbytes;

  vid_dma_seq u_vid_dma_seq (
    .clk(clk), .rst_n(rst_n), .base_odd(BODD), .base_even(BEVEN),
    .fld_sof(fld_sof), .fld_odd(fld_odd), .if_req(if_req), .if_addr(if_addr),
    .if_data(if_data), .if_valid(if_valid), .fifo_data(fifo_data), .fifo_avail(fifo_avail),
    .fifo_rd(fifo_rd), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_nbytes(wr_nbytes), .wr_sol(wr_sol), .wr_eol(wr_eol),
    .pc(pc), .irq(irq), .err(err));

  typedef struct { int k; logic [31:0] a; logic [31:0] d; int n; bit s; bit e; } ev_t;
  ev_t evq[$];
  logic [31:0] fq[$], mq[$];
  logic [31:0] mem [int];
  int vecs = 0, bad = 0, cyc = 0, dcount = 0;
  bit act, pend_sof, pend_odd, done;

  int m_mode, m_rem;
  logic [31:0] m_pc, m_addr, m_nxt, m_ir;
  bit m_busy, m_wr, m_first, m_par, m_err;

  task automatic chk(bit ok, string msg);
    vecs++;
    if (!ok) begin bad++; $display("FAIL %s", msg); end
  endtask

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 32'h0;
  endfunction

  function automatic logic [31:0] cw(logic [3:0] op, bit s, bit e, bit i, int cnt);
    return {op, s, e, 1'b0, i, 12'h0, 12'(cnt)};
  endfunction

  function automatic int olen(logic [3:0] op);
    case (op)
      4'h1, 4'h7, 4'h8, 4'hA: return 2;
      4'h2, 4'h5: return 1;
      4'h9: return 5;
      4'hB: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic ev_push(int k, logic [31:0] a, logic [31:0] d, int n, bit s, bit e);
    ev_t x;
    x.k = k; x.a = a; x.d = d; x.n = n; x.s = s; x.e = e;
    evq.push_back(x);
  endtask

  task automatic model_advance();
    logic [31:0] w0, w1;
    logic [3:0] op;
    int len, n;
    while (m_mode == 1) begin
      if (!m_busy) begin
        w0 = rd(m_pc); op = w0[31:28]; len = olen(op);
        if (len == 0) begin m_mode = 3; m_err = 1; m_pc += 4; return; end
        w1 = rd(m_pc + 4); m_pc += 32'(4 * len); m_ir = w0;
        if (op == 4'h7) begin
          m_pc = w1;
          if (w0[24]) ev_push(2, 0, 0, 0, 0, 0);
        end else if (op == 4'h8) begin
          m_mode = 2; m_par = w0[0]; return;
        end else begin
          m_busy = 1; m_first = 1; m_rem = int'(w0[11:0]);
          m_wr = (op == 4'h1) || (op == 4'h5) || (op == 4'h9) || (op == 4'hB);
          m_addr = (op == 4'h5) ? m_nxt : w1;
        end
      end else begin
        while (m_rem > 0) begin
          if (mq.size() == 0) return;
          n = (m_rem >= 4) ? 4 : m_rem;
          ev_push(m_wr ? 0 : 1, m_addr, mq.pop_front(), n, m_first && m_ir[27], m_ir[26] && (m_rem <= 4));
          m_rem -= n; m_addr += 32'(n); m_first = 0;
        end
        m_busy = 0;
        if (m_wr) m_nxt = m_addr;
        if (m_ir[24]) ev_push(2, 0, 0, 0, 0, 0);
      end
    end
  endtask

  task automatic model_sof(bit odd);
    if (m_mode == 3) return;
    if (m_mode == 2 && odd == m_par) begin
      m_mode = 1;
      if (m_ir[24]) ev_push(2, 0, 0, 0, 0, 0);
    end else begin
      m_pc = odd ? BODD : BEVEN; m_busy = 0; m_mode = 1;
    end
    model_advance();
  endtask

  task automatic step();
    ev_t e;
    @(negedge clk);
    fld_sof = pend_sof; fld_odd = pend_odd; pend_sof = 0;
    if_valid = if_req && ($urandom_range(3) != 0);
    if_data = rd(if_addr);
    fifo_data = (fq.size() != 0) ? fq[0] : 32'h0;
    fifo_avail = 10'((fq.size() > 255 ? 255 : fq.size()) * 4);
    wr_ready = ($urandom_range(2) != 0);
    #2;
    act = if_req || wr_valid || fifo_rd || irq;
    if (irq) begin
      if (evq.size() == 0 || evq[0].k != 2)
        chk(0, $sformatf("R10 irq: got 1 expected %0s", evq.size() ? "data event" : "nothing"));
      else begin void'(evq.pop_front()); chk(1, "R10"); end
    end
    if (wr_valid && wr_ready && !fifo_rd) chk(0, "R13 accepted beat without pop: got fifo_rd 0 expected 1");
    if (fifo_rd) begin
      void'(fq.pop_front());
      if (evq.size() == 0) chk(0, $sformatf("R4 pop: got write=%0d expected no pop", wr_valid));
      else begin
        e = evq.pop_front();
        if (wr_valid && wr_ready)
          chk(e.k == 0 && e.a == wr_addr && e.d == wr_data && e.n == int'(wr_nbytes) && e.s == wr_sol && e.e == wr_eol,
              $sformatf("R4 R9 R13 write: got k0 a=%h d=%h n=%0d s=%0d e=%0d expected k%0d a=%h d=%h n=%0d s=%0d e=%0d",
                        wr_addr, wr_data, wr_nbytes, wr_sol, wr_eol, e.k, e.a, e.d, e.n, e.s, e.e));
        else
          chk(e.k == 1, $sformatf("R6 skip pop: got k1 expected k%0d a=%h", e.k, e.a));
      end
    end
  endtask

  task automatic settle(string req);
    int q = 0, n = 0;
    while (q < 24 && n < 4000) begin
      step(); n++;
      q = act ? 0 : q + 1;
    end
    chk(n < 4000, $sformatf("%s settle: got %0d busy cycles expected quiet", req, n));
    chk(evq.size() == 0, $sformatf("%s events: got %0d pending expected 0", req, evq.size()));
    evq.delete();
    chk(pc == m_pc, $sformatf("%s pc: got %h expected %h", req, pc, m_pc));
    chk(err == m_err, $sformatf("%s err: got %0d expected %0d", req, err, m_err));
  endtask

  task automatic push(int n);
    for (int i = 0; i < n; i++) begin
      fq.push_back(32'hD000_0000 + 32'(dcount));
      mq.push_back(32'hD000_0000 + 32'(dcount));
      dcount++;
    end
    model_advance();
  endtask

  task automatic sof(bit odd);
    pend_sof = 1; pend_odd = odd;
    model_sof(odd);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; bad++;
      $display("FAIL R1 watchdog: got %0d cycles expected fewer than 150000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    mem[32'h1000] = cw(4'h1, 1, 0, 0, 10);  mem[32'h1004] = 32'h8000;
    mem[32'h1008] = cw(4'h5, 0, 1, 1, 6);
    mem[32'h100C] = cw(4'h2, 0, 0, 0, 8);
    mem[32'h1010] = cw(4'h7, 0, 0, 1, 0);   mem[32'h1014] = 32'h1100;
    mem[32'h1100] = cw(4'h9, 1, 1, 0, 5);   mem[32'h1104] = 32'h9000;
    mem[32'h1108] = 32'h1; mem[32'h110C] = 32'h2; mem[32'h1110] = 32'h3;
    mem[32'h1114] = cw(4'hA, 0, 0, 0, 4);   mem[32'h1118] = 32'h4;
    mem[32'h111C] = cw(4'hB, 0, 0, 1, 0);   mem[32'h1120] = 32'hA000; mem[32'h1124] = 32'h5;
    mem[32'h1128] = cw(4'h5, 0, 0, 0, 3);
    mem[32'h112C] = cw(4'h8, 0, 0, 1, 1);   mem[32'h1130] = 32'h0;
    mem[32'h1134] = cw(4'h1, 0, 1, 0, 8);   mem[32'h1138] = 32'hB000;
    mem[32'h113C] = cw(4'h3, 0, 0, 0, 4);
    mem[32'h2000] = cw(4'h1, 1, 0, 0, 16);  mem[32'h2004] = 32'hC000;

    m_mode = 0; m_pc = 0; m_nxt = 0; m_ir = 0; m_busy = 0; m_err = 0; m_par = 0; m_rem = 0;
    rst_n = 0; fld_sof = 0; fld_odd = 0; if_valid = 0; if_data = 0;
    fifo_data = 0; fifo_avail = 0; wr_ready = 0; pend_sof = 0; pend_odd = 0; done = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    #2;
    chk(pc == 0 && !err && !irq && !if_req && !wr_valid && !fifo_rd,
        $sformatf("R1 reset: got pc=%h err=%0d irq=%0d req=%0d wv=%0d rd=%0d expected all 0",
                  pc, err, irq, if_req, wr_valid, fifo_rd));
    push(11);
    settle("R1 idle with data");
    sof(1);
    settle("R2 R3 R4 R5 R6 R7 R9 R10 R12 R8 odd program to sync");
    sof(0);
    settle("R8 R2 mismatched field restarts even program");
    push(2);
    settle("R4 R9 partial even write stalls");
    sof(1);
    settle("R2 restart during stalled write");
    push(11);
    settle("R5 R6 R12 odd program again to sync");
    sof(1);
    settle("R8 R10 matching field releases sync");
    push(2);
    settle("R11 unknown opcode halts");
    sof(0);
    push(3);
    settle("R11 halted engine ignores field start and data");
    chk(fq.size() == 3, $sformatf("R11 fifo untouched: got %0d words expected 3", fq.size()));
    done = 1;
    summary();
    $finish;
  end
endmodule